// File: doc/BRIEF.md
# Byte-stream packet device register block

This block is a small packet device behind a 32-bit processor register window. Software identifies the device through a constant ID, watches a busy flag, drains received packets one byte per read of a data port, and queues a packet for transmission by writing a byte count and then exactly that many bytes to a second data port. On the device side, a byte stream with a last-byte marker fills an internal receive buffer. A second byte stream, under valid/ready flow control, empties the transmit buffer.

Three interrupt sources are combined onto one interrupt line: transmit completion, receive data available, and a software test bit. While the receive-available bit is set, the device accepts no new packet. Each read of the receive data port lowers the receive count by one, so the count always shows how many bytes are left to read.

Top module: `pktdev`

## Requirements
- R1: A read at byte offset 0x00 returns 0x4C544B50 and a read at 0x04 returns 0x314B4E49. Together these form the 64-bit ID "PKTLINK1", with the first character 'P' in bits 7:0 and the version digit '1' in bits 63:56.
- R2: Offset 0x08 reads 1 in bit 0 from the first accepted receive byte until that packet's last byte, and from a transmit-count write until the last transmit byte is handed off. Otherwise it reads 0, and writes to it have no effect.
- R3: In the cycle the last byte of a packet is accepted (rx_valid_i, rx_ready_o and rx_last_i all high), the receive count at offset 0x0C is loaded with the packet's byte length and interrupt-control bit 1 is set.
- R4: Each read of offset 0x1C while the receive count is nonzero returns the next packet byte, in arrival order, in bits 7:0 with bits 31:8 zero, and lowers the count by one.
- R5: A read of offset 0x1C while the receive count is zero returns 0 and leaves the count at zero.
- R6: rx_ready_o is low, and no byte is taken, while interrupt-control bit 1 is set or the receive count is nonzero.
- R7: After a write of N to offset 0x10 (clamped to BUF_DEPTH), the first N bytes written to offset 0x20 (bits 7:0) leave on tx_data_o in the same order. tx_last_o is high on the Nth byte, data holds while tx_ready_i is low, and further data writes are ignored.
- R8: When the last transmit byte is handed off, the transmit count at 0x10 reads 0 and interrupt-control bit 0 is set from the next cycle.
- R9: Writing 1 to bit 0 or bit 1 of interrupt control (offset 0x14) clears that bit. Writing 0 to a bit leaves it unchanged.
- R10: Writing interrupt control with bit 31 = 1 sets the test bit, and writing it with bit 31 = 0 clears it. A read of 0x14 returns the bit and clears it afterwards.
- R11: irq_o is high exactly when any of interrupt-control bits 0, 1 or 31 is set.
- R12: Offset 0x18 reads the IRQ_INFO parameter. Offset 0x20 and all offsets from 0x24 to 0x3C read 0.
- R13: A write to offset 0x10 while the transmit count is nonzero, or a write of 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset bits 5:2 (word index) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Receive byte ends the packet |
| rx_ready_o | output | 1 | Device accepts a receive byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Transmit byte ends the packet |
| tx_ready_i | input | 1 | Sink takes the transmit byte |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker checks these rules on every cycle: the receive blocking rule, the count load and pending-bit set on a last byte, the decrement on each data-port read, the zero result of an empty read, hold of the transmit byte under back-pressure, count clear and done-bit set after the final handoff, and the lock on the transmit count. Byte ordering through both buffers, clamping of oversized counts, dropping of excess data writes, and the clear-on-read life of the test bit can only be shown by the bench's scenarios. In those scenarios a behavioural queue model is compared against every output on each clock.

// File: rtl/pktdev_pkg.sv
`timescale 1ns/1ps
package pktdev_pkg;
  // word index = byte offset >> 2
  localparam logic [3:0] A_ID_LO = 4'h0;
  localparam logic [3:0] A_ID_HI = 4'h1;
  localparam logic [3:0] A_BUSY  = 4'h2;
  localparam logic [3:0] A_RXCNT = 4'h3;
  localparam logic [3:0] A_TXCNT = 4'h4;
  localparam logic [3:0] A_ICTL  = 4'h5;
  localparam logic [3:0] A_IINFO = 4'h6;
  localparam logic [3:0] A_RXDAT = 4'h7;
  localparam logic [3:0] A_TXDAT = 4'h8;

  // leftmost character lands in the top byte, so 'P' sits in bits 7:0
  localparam logic [63:0] DEV_ID = "1KNILTKP";

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_FILL = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/pktdev_rx_buf.sv
`timescale 1ns/1ps
module pktdev_rx_buf #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  input  logic             hold_i,
  input  logic             pop_i,
  output logic [7:0]       pop_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             loaded_o,
  output logic             active_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] fill_q, cnt_q, fill_nxt;
  logic [PTR_W-1:0] rd_ptr_q;
  logic             active_q, accept, room, pop_ok;

  assign s_ready_o  = !hold_i && (cnt_q == '0);
  assign accept     = s_valid_i && s_ready_o;
  assign room       = fill_q < CNT_W'(DEPTH);
  assign fill_nxt   = room ? fill_q + CNT_W'(1) : fill_q;
  assign loaded_o   = accept && s_last_i;
  assign pop_ok     = pop_i && (cnt_q != '0);
  assign pop_data_o = (cnt_q != '0) ? mem_q[rd_ptr_q] : 8'h00;
  assign count_o    = cnt_q;
  assign active_o   = active_q;

  // bytes past the buffer depth are dropped, length saturates
  always_ff @(posedge clk_i) begin
    if (accept && room) mem_q[fill_q[PTR_W-1:0]] <= s_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      active_q <= 1'b0;
    end else if (accept) begin
      if (s_last_i) begin
        cnt_q    <= fill_nxt;
        fill_q   <= '0;
        rd_ptr_q <= '0;
        active_q <= 1'b0;
      end else begin
        fill_q   <= fill_nxt;
        active_q <= 1'b1;
      end
    end else if (pop_ok) begin
      cnt_q    <= cnt_q - CNT_W'(1);
      rd_ptr_q <= rd_ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/pktdev_tx_buf.sv
`timescale 1ns/1ps
module pktdev_tx_buf
  import pktdev_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_i,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             m_last_o,
  input  logic             m_ready_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, wr_q, rd_q;
  tx_state_e        state_q;

  assign m_valid_o = (state_q == TX_SEND);
  assign m_data_o  = mem_q[rd_q[PTR_W-1:0]];
  assign m_last_o  = m_valid_o && (rd_q == cnt_q - CNT_W'(1));
  assign done_o    = m_valid_o && m_ready_i && m_last_o;
  assign busy_o    = (state_q != TX_IDLE);
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (state_q == TX_FILL && dat_we_i) mem_q[wr_q[PTR_W-1:0]] <= dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (cnt_we_i && cnt_wdata_i != '0) begin
          cnt_q   <= cnt_wdata_i;
          wr_q    <= '0;
          state_q <= TX_FILL;
        end
        TX_FILL: if (dat_we_i) begin
          wr_q <= wr_q + CNT_W'(1);
          if (wr_q + CNT_W'(1) == cnt_q) begin
            rd_q    <= '0;
            state_q <= TX_SEND;
          end
        end
        TX_SEND: if (m_ready_i) begin
          rd_q <= rd_q + CNT_W'(1);
          if (m_last_o) begin
            cnt_q   <= '0;
            state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pktdev_irq.sv
`timescale 1ns/1ps
module pktdev_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_set_i,
  input  logic rx_set_i,
  input  logic ctl_wr_i,
  input  logic ctl_rd_i,
  input  logic clr_tx_i,
  input  logic clr_rx_i,
  input  logic test_i,
  output logic tx_done_o,
  output logic rx_pend_o,
  output logic test_o,
  output logic irq_o
);
  logic tx_q, rx_q, test_q;

  // a new event outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      test_q <= 1'b0;
    end else begin
      if (tx_set_i)                  tx_q <= 1'b1;
      else if (ctl_wr_i && clr_tx_i) tx_q <= 1'b0;
      if (rx_set_i)                  rx_q <= 1'b1;
      else if (ctl_wr_i && clr_rx_i) rx_q <= 1'b0;
      if (ctl_wr_i)      test_q <= test_i;
      else if (ctl_rd_i) test_q <= 1'b0;
    end
  end

  assign tx_done_o = tx_q;
  assign rx_pend_o = rx_q;
  assign test_o    = test_q;
  assign irq_o     = tx_q | rx_q | test_q;
endmodule

// File: rtl/pktdev.sv
`timescale 1ns/1ps
module pktdev
  import pktdev_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 256,
  parameter int unsigned MAX_PKT   = 65536,
  parameter logic [31:0] IRQ_INFO  = 32'h0000_0102
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [5:2]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        irq_o
);
  localparam int unsigned CNT_W = $clog2(MAX_PKT + 1);

  logic             rd_en, wr_en;
  logic [CNT_W-1:0] rx_count, tx_count, tx_cnt_wr;
  logic [7:0]       rx_byte;
  logic             rx_loaded, rx_active, tx_done_ev, tx_busy, busy;
  logic             tx_done_bit, rx_pend, test_bit;

  assign rd_en = bus_sel_i && !bus_we_i;
  assign wr_en = bus_sel_i && bus_we_i;
  assign busy  = rx_active | tx_busy;

  // oversized requests are clamped to what the buffer holds
  assign tx_cnt_wr = (bus_wdata_i > 32'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH)
                                                    : bus_wdata_i[CNT_W-1:0];

  pktdev_rx_buf #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_valid_i (rx_valid_i),
    .s_data_i  (rx_data_i),
    .s_last_i  (rx_last_i),
    .s_ready_o (rx_ready_o),
    .hold_i    (rx_pend),
    .pop_i     (rd_en && bus_addr_i == A_RXDAT),
    .pop_data_o(rx_byte),
    .count_o   (rx_count),
    .loaded_o  (rx_loaded),
    .active_o  (rx_active)
  );

  pktdev_tx_buf #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_we_i   (wr_en && bus_addr_i == A_TXCNT),
    .cnt_wdata_i(tx_cnt_wr),
    .dat_we_i   (wr_en && bus_addr_i == A_TXDAT),
    .dat_i      (bus_wdata_i[7:0]),
    .m_valid_o  (tx_valid_o),
    .m_data_o   (tx_data_o),
    .m_last_o   (tx_last_o),
    .m_ready_i  (tx_ready_i),
    .count_o    (tx_count),
    .done_o     (tx_done_ev),
    .busy_o     (tx_busy)
  );

  pktdev_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_set_i (tx_done_ev),
    .rx_set_i (rx_loaded),
    .ctl_wr_i (wr_en && bus_addr_i == A_ICTL),
    .ctl_rd_i (rd_en && bus_addr_i == A_ICTL),
    .clr_tx_i (bus_wdata_i[0]),
    .clr_rx_i (bus_wdata_i[1]),
    .test_i   (bus_wdata_i[31]),
    .tx_done_o(tx_done_bit),
    .rx_pend_o(rx_pend),
    .test_o   (test_bit),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (bus_addr_i)
        A_ID_LO: bus_rdata_o = DEV_ID[31:0];
        A_ID_HI: bus_rdata_o = DEV_ID[63:32];
        A_BUSY:  bus_rdata_o = 32'(busy);
        A_RXCNT: bus_rdata_o = 32'(rx_count);
        A_TXCNT: bus_rdata_o = 32'(tx_count);
        A_ICTL:  bus_rdata_o = {test_bit, 29'b0, rx_pend, tx_done_bit};
        A_IINFO: bus_rdata_o = IRQ_INFO;
        A_RXDAT: bus_rdata_o = 32'(rx_byte);
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pktdev_chk.sv
`timescale 1ns/1ps
module pktdev_chk
  import pktdev_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [5:2]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic             rx_valid_i,
  input logic             rx_last_i,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_last_o,
  input logic             tx_ready_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic             busy_i,
  input logic             rx_pend_i,
  input logic             tx_done_i
);
  logic rd, wr, tx_fin;
  assign rd     = bus_sel_i && !bus_we_i;
  assign wr     = bus_sel_i && bus_we_i;
  assign tx_fin = tx_valid_o && tx_ready_i && tx_last_o;

  assert_id_lo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == A_ID_LO) |-> bus_rdata_o == 32'h4C544B50);

  assert_busy_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy_i);

  assert_rx_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && rx_last_i) |=> (rx_count_i != '0 && rx_pend_i));

  assert_rx_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == A_RXDAT && rx_count_i != '0)
      |=> rx_count_i == $past(rx_count_i) - CNT_W'(1));

  assert_rx_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == A_RXDAT && rx_count_i == '0) |-> bus_rdata_o == '0);

  assert_rx_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pend_i |-> !rx_ready_o);

  assert_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i)
      |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  assert_tx_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fin |=> (tx_count_i == '0 && tx_done_i));

  assert_test_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_ICTL && bus_wdata_i[31]) |=> irq_o);

  assert_txcnt_lock_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_TXCNT && tx_count_i != '0 && !tx_fin)
      |=> $stable(tx_count_i));

  logic unused_ok;
  assign unused_ok = &{1'b0, rx_last_i};
endmodule

bind pktdev pktdev_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .rx_valid_i (rx_valid_i),
  .rx_last_i  (rx_last_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_last_o  (tx_last_o),
  .tx_ready_i (tx_ready_i),
  .irq_o      (irq_o),
  .rx_count_i (rx_count),
  .tx_count_i (tx_count),
  .busy_i     (busy),
  .rx_pend_i  (rx_pend),
  .tx_done_i  (tx_done_bit)
);

// File: tb/pktdev_tb.sv
`timescale 1ns/1ps
module pktdev_tb;
  localparam int          DEPTH = 256;
  localparam logic [31:0] INFO  = 32'h0000_0102;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  bit          stall = 1'b0;

  always #4 clk = ~clk;

  pktdev #(.BUF_DEPTH(DEPTH), .MAX_PKT(65536), .IRQ_INFO(INFO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .irq_o(irq)
  );

  int n_cmp = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_rxq[$], m_rxbuf[$], m_txq[$], got[$];
  int m_rxcnt = 0, m_txcnt = 0, m_txidx = 0, m_txst = 0;
  bit m_rxact = 0, m_txb = 0, m_rxb = 0, m_tst = 0;
  bit md_rd, md_wr, md_acc, md_rxset, md_txset;
  int md_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxq.delete(); m_rxbuf.delete(); m_txq.delete();
      m_rxcnt = 0; m_txcnt = 0; m_txidx = 0; m_txst = 0;
      m_rxact = 0; m_txb = 0; m_rxb = 0; m_tst = 0;
    end else begin
      md_rd = sel && !we; md_wr = sel && we; md_w = int'(addr);
      md_acc = rx_valid && !m_rxb && m_rxcnt == 0;
      md_rxset = 0; md_txset = 0;
      if (md_acc) begin
        if (m_rxq.size() < DEPTH) m_rxq.push_back(rx_data);
        if (rx_last) begin
          m_rxbuf = m_rxq; m_rxcnt = m_rxq.size(); m_rxq.delete();
          m_rxact = 0; md_rxset = 1;
        end else m_rxact = 1;
      end else if (md_rd && md_w == 7 && m_rxcnt > 0) begin
        void'(m_rxbuf.pop_front());
        m_rxcnt--;
      end
      case (m_txst)
        0: if (md_wr && md_w == 4 && wdata != 0) begin
          m_txcnt = (wdata > 32'(DEPTH)) ? DEPTH : int'(wdata);
          m_txq.delete(); m_txst = 1;
        end
        1: if (md_wr && md_w == 8) begin
          m_txq.push_back(wdata[7:0]);
          if (m_txq.size() == m_txcnt) begin m_txst = 2; m_txidx = 0; end
        end
        default: if (tx_ready) begin
          if (m_txidx == m_txcnt - 1) begin m_txst = 0; m_txcnt = 0; md_txset = 1; end
          else m_txidx++;
        end
      endcase
      if (md_txset) m_txb = 1;
      else if (md_wr && md_w == 5 && wdata[0]) m_txb = 0;
      if (md_rxset) m_rxb = 1;
      else if (md_wr && md_w == 5 && wdata[1]) m_rxb = 0;
      if (md_wr && md_w == 5) m_tst = wdata[31];
      else if (md_rd && md_w == 5) m_tst = 0;
    end
  end

  function automatic logic [31:0] exp_rdata(input int w);
    case (w)
      0: return 32'h4C544B50;
      1: return 32'h314B4E49;
      2: return 32'(m_rxact || m_txst != 0);
      3: return 32'(m_rxcnt);
      4: return 32'(m_txcnt);
      5: return {m_tst, 29'b0, m_rxb, m_txb};
      6: return INFO;
      7: return (m_rxcnt > 0) ? 32'(m_rxbuf[0]) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      0, 1: return "R1 id word";
      2: return "R2 busy";
      3: return "R3 rx count";
      4: return "R13 tx count";
      5: return "R9 int ctl";
      6: return "R12 info";
      7: return "R4 rx data";
      default: return "R12 unmapped";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      chk("R6 rx_ready", 32'(rx_ready), 32'(!m_rxb && m_rxcnt == 0));
      chk("R7 tx_valid", 32'(tx_valid), 32'(m_txst == 2));
      if (m_txst == 2 && tx_valid) begin
        chk("R7 tx_data", 32'(tx_data), 32'(m_txq[m_txidx]));
        chk("R7 tx_last", 32'(tx_last), 32'(m_txidx == m_txcnt - 1));
        if (tx_ready) got.push_back(tx_data);
      end
      chk("R11 irq", 32'(irq), 32'(m_txb | m_rxb | m_tst));
      if (sel && !we) chk(tag_of(int'(addr)), rdata, exp_rdata(int'(addr)));
    end
  end

  always @(negedge clk) tx_ready <= stall ? ($time / 8 % 3 != 1) : 1'b1;

  // ---------------- stimulus tasks ----------------
  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk); sel = 1; we = 0; addr = a[5:2];
    #3 chk(tag, rdata, exp);
    @(negedge clk); sel = 0;
  endtask

  task automatic rdv(input int a, output logic [31:0] v);
    @(negedge clk); sel = 1; we = 0; addr = a[5:2];
    #3 v = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a[5:2]; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rx_send(input logic [7:0] pkt[$]);
    foreach (pkt[i]) begin
      @(negedge clk);
      rx_valid = 1; rx_data = pkt[i]; rx_last = (i == pkt.size() - 1);
      #3;
      while (!rx_ready) begin @(negedge clk); #3; end
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic wait_tx_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rdv('h10, v);
      if (v == 0) break;
    end
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] pkt[$];
    repeat (3) @(negedge clk);
    #3 chk("R11 irq at reset", 32'(irq), 0);
    chk("R6 ready at reset", 32'(rx_ready), 1);
    rst_n = 1;

    rd('h00, 32'h4C544B50, "R1 id low");
    rd('h04, 32'h314B4E49, "R1 id high");
    rd('h08, 0, "R2 idle busy");
    rd('h18, INFO, "R12 info");
    rd('h20, 0, "R12 tx data reads zero");
    rd('h24, 0, "R12 unmapped");
    rd('h3C, 0, "R12 unmapped top");

    // packet of 3 with busy seen mid-packet
    @(negedge clk); rx_valid = 1; rx_data = 8'h01; rx_last = 0;
    @(negedge clk); rx_valid = 0;
    rd('h08, 1, "R2 busy during rx");
    rx_send('{8'h02, 8'h03});
    rd('h0C, 3, "R3 count loaded");
    rd('h14, 2, "R3 rx bit set");
    wr('h14, 1);
    rd('h14, 2, "R9 other bit untouched");
    for (int i = 1; i <= 3; i++) rd('h1C, 32'(i), "R4 rx byte order");
    rd('h1C, 0, "R5 empty read");
    rd('h0C, 0, "R5 count stays zero");

    // offered packet held off while the rx bit stays set
    @(negedge clk); rx_valid = 1; rx_data = 8'hEE; rx_last = 1;
    repeat (3) begin #3 chk("R6 blocked by rx bit", 32'(rx_ready), 0); @(negedge clk); end
    rd('h0C, 0, "R6 nothing taken");
    wr('h14, 2);
    @(negedge clk); rx_valid = 0; rx_last = 0;
    rd('h0C, 1, "R3 single byte packet");
    rd('h1C, 32'hEE, "R4 single byte");
    wr('h14, 2);
    rd('h14, 0, "R9 rx bit cleared");

    pkt = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    rx_send(pkt);
    for (int i = 0; i < 5; i++) begin
      rd('h1C, 32'(pkt[i]), "R4 rx byte");
      rd('h0C, 32'(4 - i), "R4 count decrements");
    end
    wr('h14, 2);

    // transmit with back-pressure
    stall = 1;
    got.delete();
    wr('h10, 4);
    rd('h08, 1, "R2 busy during tx fill");
    wr('h08, 0);
    rd('h08, 1, "R2 write ignored");
    wr('h10, 9);
    rd('h10, 4, "R13 count locked");
    for (int i = 0; i < 6; i++) wr('h20, 32'h1A0 + 32'(i));
    wait_tx_idle();
    chk("R7 tx byte count", 32'(got.size()), 4);
    for (int i = 0; i < 4 && i < got.size(); i++)
      chk("R7 tx byte order", 32'(got[i]), 32'hA0 + 32'(i));
    rd('h10, 0, "R8 count cleared");
    rd('h14, 1, "R8 tx done bit");
    wr('h14, 1);
    rd('h14, 0, "R9 tx bit cleared");
    wr('h10, 0);
    rd('h10, 0, "R13 zero write ignored");

    // oversized count clamps to buffer depth
    stall = 0;
    got.delete();
    wr('h10, 300);
    rd('h10, 32'(DEPTH), "R7 clamp to depth");
    for (int i = 0; i < DEPTH; i++) wr('h20, 32'(i));
    wait_tx_idle();
    chk("R7 clamped packet size", 32'(got.size()), 32'(DEPTH));
    for (int i = 0; i < DEPTH && i < got.size(); i++)
      chk("R7 clamped byte", 32'(got[i]), 32'(i % 256));
    wr('h14, 1);

    // test interrupt bit
    wr('h14, 32'h8000_0000);
    #3 chk("R10 test raises irq", 32'(irq), 1);
    rd('h14, 32'h8000_0000, "R10 test bit read");
    rd('h14, 0, "R10 cleared by read");
    chk("R11 irq low after read", 32'(irq), 0);
    wr('h14, 32'h8000_0000);
    wr('h14, 0);
    rd('h14, 0, "R10 write zero clears");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule